// File: doc/BRIEF.md
# Add-Only Memory Command Engine

This block is the memory-command layer that sits behind the bit-level and ROM-selection layers of a single-wire slave. It gives byte-level access to two write-once arrays held in registers: a 128-byte data array split into four 32-byte pages, and an 8-byte status array. A transaction opens with a command byte, continues with a two-byte address sent low byte first, and, for the two write commands, one data byte. The engine answers with a CRC of the received bytes and then streams read data or accepts programming.

Bytes arrive on a one-cycle receive strobe. Replies are requested with a one-cycle transmit request and always come back on the following cycle; where nothing is defined, the reply is FFh. A programming-pulse detect input commits a pending write. Programming can only clear bits. A bus reset event aborts the current command at any point.

Top module: `amc_engine`

## Requirements
- R1: After `rst_n`, `tx_valid` is low, every data byte reads FFh, status bytes 0 to 6 read FFh and status byte 7 reads 00h.
- R2: Every `tx_req` pulse produces exactly one `tx_valid` pulse in the next cycle. The first reply after the header is the CRC (x^8+x^5+x^4+1, bits LSB first, register starting at 00h) over the command byte, the masked address low byte, a high byte of 00h and, for writes, the data byte.
- R3: Only the low 7 address bits are kept for data commands and only the low 3 for status commands. The high address byte is treated as 00h, in the CRC as well.
- R4: Command 0Fh programs data and 55h programs status. On a programming pulse the addressed byte becomes the old value ANDed with the data byte, and the next reply returns the stored byte.
- R5: After that verify reply the address increments (wrapping within its array). The CRC is then loaded with the new address low byte, the next received data byte is shifted in, and the result is the next reply.
- R6: A 0 in bit p of status byte 0 (p = 0..3, page = data address bits 6:5) blocks programming of data page p. Reads of that page are unaffected.
- R7: Command F0h returns data bytes up to address 7Fh, then a CRC (started at 00h) of the bytes returned, then FFh.
- R8: Command C3h returns data bytes and, after the last byte of each 32-byte page, a CRC of that page's bytes. The CRC restarts for the next page, and FFh follows the CRC of page 3.
- R9: Command AAh returns status bytes up to byte 7, then a CRC of those bytes, then FFh.
- R10: A programming pulse outside the wait that follows the write CRC reply changes no byte.
- R11: A bus reset event aborts any command and discards the received data byte. The next received byte is taken as a command.
- R12: An unknown command byte makes every later reply FFh and leaves memory unchanged until a bus reset event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_reset | input | 1 | One-cycle bus reset event, aborts the command |
| rx_valid | input | 1 | Strobe: `rx_byte` holds a byte from the master |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Strobe: the master wants the next byte |
| tx_valid | output | 1 | Reply strobe, one cycle after `tx_req` |
| tx_byte | output | 8 | Reply byte |
| pgm_pulse | input | 1 | Programming-pulse detect strobe |

## Verification
The hardest states to reach are stray programming pulses that arrive in other protocol phases. These include a pulse after the data byte but before the CRC has been read, a pulse after an unknown command, and a pulse right after a bus reset that aborted a pending write. The bench places these pulses between ordinary header bytes and then reads memory back through a full-page CRC read, so any stray commit shows up in the data. Page protection is reached by first programming status byte 0 and then writing into the protected page. The stream of auto-incremented writes is driven across the end of the status array, so that the wrap and the fixed 00h byte are both exercised.

// File: rtl/amc_pkg.sv
package amc_pkg;

  localparam logic [7:0] OP_RD_DATA = 8'hF0;
  localparam logic [7:0] OP_RD_PAGE = 8'hC3;
  localparam logic [7:0] OP_RD_STAT = 8'hAA;
  localparam logic [7:0] OP_WR_DATA = 8'h0F;
  localparam logic [7:0] OP_WR_STAT = 8'h55;

  typedef enum logic [3:0] {
    ST_CMD, ST_ALO, ST_AHI, ST_DAT, ST_WCRC, ST_WAIT,
    ST_VFY, ST_RCRC, ST_RDAT, ST_TCRC, ST_ONES
  } amc_state_t;

  typedef enum logic [2:0] {
    K_NONE, K_RD_DATA, K_RD_PAGE, K_RD_STAT, K_WR_DATA, K_WR_STAT
  } amc_kind_t;

  function automatic amc_kind_t amc_decode(input logic [7:0] op);
    case (op)
      OP_RD_DATA: return K_RD_DATA;
      OP_RD_PAGE: return K_RD_PAGE;
      OP_RD_STAT: return K_RD_STAT;
      OP_WR_DATA: return K_WR_DATA;
      OP_WR_STAT: return K_WR_STAT;
      default:    return K_NONE;
    endcase
  endfunction

  // One byte through the reflected x^8+x^5+x^4+1 register, bit 0 first.
  function automatic logic [7:0] amc_crc_byte(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    logic       fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ b[k];
      r  = {1'b0, r[7:1]};
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

endpackage

// File: rtl/amc_crc8.sv
module amc_crc8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] seed,
  input  logic       shift,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import amc_pkg::*;

  logic [7:0] crc_nx;

  always_comb begin
    crc_nx = crc;
    if (clr)        crc_nx = 8'h00;
    else if (load)  crc_nx = seed;
    else if (shift) crc_nx = amc_crc_byte(crc, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= 8'h00;
    else        crc <= crc_nx;
  end
endmodule

// File: rtl/amc_store.sv
module amc_store #(
  parameter int DATA_BYTES = 128,
  parameter int PAGE_BYTES = 32,
  parameter int STAT_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(DATA_BYTES)-1:0] d_addr,
  input  logic [$clog2(STAT_BYTES)-1:0] s_addr,
  input  logic                          d_wr,
  input  logic                          s_wr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    d_rdata,
  output logic [7:0]                    s_rdata
);
  localparam int DA_W  = $clog2(DATA_BYTES);
  localparam int PAGES = DATA_BYTES / PAGE_BYTES;
  localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam logic [STAT_BYTES*8-1:0] S_INIT = {8'h00, {(STAT_BYTES-1){8'hFF}}};

  logic [DATA_BYTES-1:0][7:0] dmem, dmem_nx;
  logic [STAT_BYTES-1:0][7:0] smem, smem_nx;
  logic [PG_W-1:0]            page;
  logic                       page_open;
  logic                       d_commit;

  generate
    if (PAGES > 1) begin : g_pg
      assign page = d_addr[DA_W-1 -: PG_W];
    end else begin : g_pg1
      assign page = '0;
    end
  endgenerate

  assign page_open = smem[0][page];
  assign d_commit  = d_wr & page_open;

  always_comb begin
    dmem_nx = dmem;
    if (d_commit) dmem_nx[d_addr] = dmem[d_addr] & wdata;
  end

  always_comb begin
    smem_nx = smem;
    if (s_wr) smem_nx[s_addr] = smem[s_addr] & wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmem <= '1;
      smem <= S_INIT;
    end else begin
      dmem <= dmem_nx;
      smem <= smem_nx;
    end
  end

  assign d_rdata = dmem[d_addr];
  assign s_rdata = smem[s_addr];

  // R4
  bits_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dmem & ~$past(dmem)) == '0) && ((smem & ~$past(smem)) == '0));

  // R6
  protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && !smem[0][page]) |=> $stable(dmem));

  // R10
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_wr && !s_wr) |=> ($stable(dmem) && $stable(smem)));
endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl #(
  parameter int DATA_BYTES = 128,
  parameter int PAGE_BYTES = 32,
  parameter int STAT_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_reset,
  input  logic                          rx_valid,
  input  logic [7:0]                    rx_byte,
  input  logic                          tx_req,
  input  logic                          pgm_pulse,
  output logic                          tx_valid,
  output logic [7:0]                    tx_byte,
  input  logic [7:0]                    crc_val,
  output logic                          crc_clr,
  output logic                          crc_load,
  output logic [7:0]                    crc_seed,
  output logic                          crc_shift,
  output logic [7:0]                    crc_din,
  output logic [$clog2(DATA_BYTES)-1:0] d_addr,
  output logic [$clog2(STAT_BYTES)-1:0] s_addr,
  output logic                          d_wr,
  output logic                          s_wr,
  output logic [7:0]                    wdata,
  input  logic [7:0]                    d_rdata,
  input  logic [7:0]                    s_rdata
);
  import amc_pkg::*;

  localparam int DA_W  = $clog2(DATA_BYTES);
  localparam int SA_W  = $clog2(STAT_BYTES);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam logic [7:0] D_MASK = 8'(DATA_BYTES - 1);
  localparam logic [7:0] S_MASK = 8'(STAT_BYTES - 1);

  amc_state_t      st, st_nx;
  amc_kind_t       kind, kind_nx, dec_kind;
  logic [DA_W-1:0] addr, addr_nx, addr_inc;
  logic [SA_W-1:0] s_inc;
  logic [7:0]      wbuf, wbuf_nx, lo_m, rd_byte;
  logic            more, more_nx;
  logic            txv_nx;
  logic [7:0]      txb_nx;
  logic            is_stat, is_wr, at_last, at_page_end;

  assign dec_kind    = amc_decode(rx_byte);
  assign is_stat     = (kind == K_RD_STAT) || (kind == K_WR_STAT);
  assign is_wr       = (kind == K_WR_DATA) || (kind == K_WR_STAT);
  assign lo_m        = rx_byte & (is_stat ? S_MASK : D_MASK);
  assign s_inc       = addr[SA_W-1:0] + 1'b1;
  assign addr_inc    = is_stat ? DA_W'(s_inc) : addr + 1'b1;
  assign at_last     = is_stat ? (addr[SA_W-1:0] == '1) : (addr == '1);
  assign at_page_end = (addr[OFS_W-1:0] == '1);
  assign rd_byte     = is_stat ? s_rdata : d_rdata;
  assign d_addr      = addr;
  assign s_addr      = addr[SA_W-1:0];
  assign wdata       = wbuf;
  assign crc_seed    = 8'(addr_inc);

  always_comb begin
    st_nx     = st;
    kind_nx   = kind;
    addr_nx   = addr;
    wbuf_nx   = wbuf;
    more_nx   = more;
    txv_nx    = tx_req;
    txb_nx    = 8'hFF;
    crc_clr   = 1'b0;
    crc_load  = 1'b0;
    crc_shift = 1'b0;
    crc_din   = 8'h00;
    d_wr      = 1'b0;
    s_wr      = 1'b0;
    if (bus_reset) begin
      st_nx   = ST_CMD;
      kind_nx = K_NONE;
      wbuf_nx = 8'hFF;
      more_nx = 1'b0;
      crc_clr = 1'b1;
    end else begin
      unique case (st)
        ST_CMD: if (rx_valid) begin
          crc_shift = 1'b1;
          crc_din   = rx_byte;
          kind_nx   = dec_kind;
          st_nx     = (dec_kind == K_NONE) ? ST_ONES : ST_ALO;
        end
        ST_ALO: if (rx_valid) begin
          crc_shift = 1'b1;
          crc_din   = lo_m;
          addr_nx   = DA_W'(lo_m);
          st_nx     = ST_AHI;
        end
        ST_AHI: if (rx_valid) begin
          crc_shift = 1'b1;
          crc_din   = 8'h00;
          st_nx     = is_wr ? ST_DAT : ST_RCRC;
        end
        ST_DAT: if (rx_valid) begin
          crc_shift = 1'b1;
          crc_din   = rx_byte;
          wbuf_nx   = rx_byte;
          st_nx     = ST_WCRC;
        end
        ST_WCRC: if (tx_req) begin
          txb_nx = crc_val;
          st_nx  = ST_WAIT;
        end
        ST_WAIT: if (pgm_pulse) begin
          d_wr  = (kind == K_WR_DATA);
          s_wr  = (kind == K_WR_STAT);
          st_nx = ST_VFY;
        end
        ST_VFY: if (tx_req) begin
          txb_nx   = rd_byte;
          addr_nx  = addr_inc;
          crc_load = 1'b1;
          st_nx    = ST_DAT;
        end
        ST_RCRC: if (tx_req) begin
          txb_nx  = crc_val;
          crc_clr = 1'b1;
          st_nx   = ST_RDAT;
        end
        ST_RDAT: if (tx_req) begin
          txb_nx    = rd_byte;
          crc_shift = 1'b1;
          crc_din   = rd_byte;
          addr_nx   = addr_inc;
          if (at_last) begin
            more_nx = 1'b0;
            st_nx   = ST_TCRC;
          end else if ((kind == K_RD_PAGE) && at_page_end) begin
            more_nx = 1'b1;
            st_nx   = ST_TCRC;
          end
        end
        ST_TCRC: if (tx_req) begin
          txb_nx  = crc_val;
          crc_clr = 1'b1;
          st_nx   = more ? ST_RDAT : ST_ONES;
        end
        ST_ONES: ;
        default: st_nx = ST_ONES;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_CMD;
      kind     <= K_NONE;
      addr     <= '0;
      wbuf     <= 8'hFF;
      more     <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= 8'hFF;
    end else begin
      st       <= st_nx;
      kind     <= kind_nx;
      addr     <= addr_nx;
      wbuf     <= wbuf_nx;
      more     <= more_nx;
      tx_valid <= txv_nx;
      tx_byte  <= txb_nx;
    end
  end

  // R11
  abort_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (st == ST_CMD && kind == K_NONE));

  // R2
  reply_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> tx_valid);

  // R2
  no_unasked_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> !tx_valid);

  // R12
  unknown_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ONES && !bus_reset) |=> (st == ST_ONES && !d_wr && !s_wr));
endmodule

// File: rtl/amc_engine.sv
module amc_engine #(
  parameter int DATA_BYTES = 128,
  parameter int PAGE_BYTES = 32,
  parameter int STAT_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  input  logic       pgm_pulse
);
  localparam int DA_W = $clog2(DATA_BYTES);
  localparam int SA_W = $clog2(STAT_BYTES);

  logic            crc_clr, crc_load, crc_shift;
  logic [7:0]      crc_seed, crc_din, crc_val;
  logic [DA_W-1:0] d_addr;
  logic [SA_W-1:0] s_addr;
  logic            d_wr, s_wr;
  logic [7:0]      wdata, d_rdata, s_rdata;

  amc_ctrl #(
    .DATA_BYTES(DATA_BYTES), .PAGE_BYTES(PAGE_BYTES), .STAT_BYTES(STAT_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .pgm_pulse(pgm_pulse), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .crc_val(crc_val), .crc_clr(crc_clr), .crc_load(crc_load),
    .crc_seed(crc_seed), .crc_shift(crc_shift), .crc_din(crc_din),
    .d_addr(d_addr), .s_addr(s_addr), .d_wr(d_wr), .s_wr(s_wr),
    .wdata(wdata), .d_rdata(d_rdata), .s_rdata(s_rdata)
  );

  amc_store #(
    .DATA_BYTES(DATA_BYTES), .PAGE_BYTES(PAGE_BYTES), .STAT_BYTES(STAT_BYTES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .d_addr(d_addr), .s_addr(s_addr),
    .d_wr(d_wr), .s_wr(s_wr), .wdata(wdata),
    .d_rdata(d_rdata), .s_rdata(s_rdata)
  );

  amc_crc8 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .load(crc_load),
    .seed(crc_seed), .shift(crc_shift), .din(crc_din), .crc(crc_val)
  );
endmodule

// File: tb/amc_engine_bench.sv
module amc_engine_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_req = 1'b0;
  logic       pgm_pulse = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_byte;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] dm [128];
  logic [7:0] sm [8];
  int         wa;
  bit         wst;
  logic [7:0] wd;

  always #(CLK_NS/2) clk = ~clk;

  amc_engine u_amc_engine (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .pgm_pulse(pgm_pulse)
  );

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int k = 0; k < 8; k++)
      r = (r >> 1) ^ (((r[0] ^ b[k]) == 1'b1) ? 8'h8C : 8'h00);
    return r;
  endfunction

  // One clock; every clock the reply strobe and byte are compared with the model.
  task automatic step(input bit ev, input logic [7:0] eb, input string tag);
    @(negedge clk);
    checks++;
    if (tx_valid !== ev || (ev && tx_byte !== eb)) begin
      fails++;
      $display("FAIL %s: actual valid=%0b byte=%02h expected valid=%0b byte=%02h",
               tag, tx_valid, tx_byte, ev, eb);
    end
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    rx_valid = 1'b1; rx_byte = b;
    step(1'b0, 8'h00, tag);
    rx_valid = 1'b0;
  endtask

  task automatic get(input logic [7:0] e, input string tag);
    tx_req = 1'b1;
    step(1'b1, e, tag);
    tx_req = 1'b0;
  endtask

  task automatic pulse(input string tag);
    pgm_pulse = 1'b1;
    step(1'b0, 8'h00, tag);
    pgm_pulse = 1'b0;
  endtask

  task automatic bevt(input string tag);
    bus_reset = 1'b1;
    step(1'b0, 8'h00, tag);
    bus_reset = 1'b0;
  endtask

  task automatic wr_start(input logic [7:0] cmd, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] d, input string tag);
    logic [7:0] c;
    wst = (cmd == 8'h55);
    wa  = wst ? int'(lo) % 8 : int'(lo) % 128;
    wd  = d;
    c = crc_step(8'h00, cmd);
    c = crc_step(c, 8'(wa));
    c = crc_step(c, 8'h00);
    c = crc_step(c, d);
    send(cmd, tag); send(lo, tag); send(hi, tag); send(d, tag);
    get(c, {tag, " R2 header crc"});
  endtask

  task automatic wr_prog(input string tag);
    logic [7:0] stored;
    pulse(tag);
    if (wst) begin
      sm[wa] = sm[wa] & wd;
      stored = sm[wa];
    end else begin
      if (sm[0][wa / 32]) dm[wa] = dm[wa] & wd;
      stored = dm[wa];
    end
    get(stored, {tag, " R4 verify"});
    wa = wst ? (wa + 1) % 8 : (wa + 1) % 128;
  endtask

  task automatic wr_more(input logic [7:0] d, input string tag);
    wd = d;
    send(d, tag);
    get(crc_step(8'(wa), d), {tag, " R5 reseeded crc"});
  endtask

  task automatic rd_all(input logic [7:0] cmd, input logic [7:0] lo,
                        input logic [7:0] hi, input string tag);
    logic [7:0] q[$];
    logic [7:0] c;
    int a;
    a = (cmd == 8'hAA) ? int'(lo) % 8 : int'(lo) % 128;
    c = crc_step(crc_step(crc_step(8'h00, cmd), 8'(a)), 8'h00);
    send(cmd, tag); send(lo, tag); send(hi, tag);
    get(c, {tag, " R2 header crc"});
    if (cmd == 8'hF0) begin
      c = 8'h00;
      for (int i = a; i < 128; i++) begin q.push_back(dm[i]); c = crc_step(c, dm[i]); end
      q.push_back(c);
    end else if (cmd == 8'hAA) begin
      c = 8'h00;
      for (int i = a; i < 8; i++) begin q.push_back(sm[i]); c = crc_step(c, sm[i]); end
      q.push_back(c);
    end else begin
      int i = a;
      while (i < 128) begin
        c = 8'h00;
        do begin q.push_back(dm[i]); c = crc_step(c, dm[i]); i++; end while (i % 32 != 0);
        q.push_back(c);
      end
    end
    for (int j = 0; j < 3; j++) q.push_back(8'hFF);
    foreach (q[j]) get(q[j], tag);
    bevt(tag);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 128; i++) dm[i] = 8'hFF;
    for (int i = 0; i < 7; i++) sm[i] = 8'hFF;
    sm[7] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 8'h00, "R1 idle after reset");
    step(1'b0, 8'h00, "R1 idle after reset");

    // R1 R7 R9: erased contents, end-of-array CRC then ones
    rd_all(8'hF0, 8'h7C, 8'h00, "R1 R7 data tail");
    rd_all(8'hAA, 8'h00, 8'h00, "R1 R9 status all");

    // R4 R5: program, verify, auto-increment, AND with old value
    wr_start(8'h0F, 8'h05, 8'h00, 8'hA5, "R4 first write");
    wr_prog("R4 first write");
    wr_more(8'h3C, "R5 next byte");
    wr_prog("R5 next byte");
    bevt("R11");
    wr_start(8'h0F, 8'h05, 8'h00, 8'h0F, "R4 and rewrite");
    wr_prog("R4 and rewrite");
    bevt("R11");

    // R3: upper address bits forced to zero
    wr_start(8'h0F, 8'hA0, 8'h01, 8'h77, "R3 masked write");
    wr_prog("R3 masked write");
    bevt("R11");
    rd_all(8'hF0, 8'h9E, 8'hFF, "R3 R7 masked read");

    // R6: protect page 1, then try to program it; page 0 stays writable
    wr_start(8'h55, 8'h00, 8'h00, 8'hFD, "R6 set protect");
    wr_prog("R6 set protect");
    bevt("R11");
    wr_start(8'h0F, 8'h25, 8'h00, 8'h00, "R6 protected page");
    wr_prog("R6 protected page");
    wr_more(8'h00, "R6 protected page");
    wr_prog("R6 protected page");
    bevt("R11");
    wr_start(8'h0F, 8'h07, 8'h00, 8'h81, "R6 open page");
    wr_prog("R6 open page");
    bevt("R11");

    // R10: stray pulses in idle, before the CRC read, and in the data phase
    pulse("R10 idle pulse");
    send(8'h0F, "R10"); send(8'h08, "R10"); send(8'h00, "R10"); send(8'h00, "R10");
    pulse("R10 early pulse");
    get(crc_step(crc_step(crc_step(crc_step(8'h00, 8'h0F), 8'h08), 8'h00), 8'h00),
        "R10 R2 crc after early pulse");
    get(8'hFF, "R10 no verify without pulse");
    bevt("R11");
    rd_all(8'hC3, 8'h00, 8'h00, "R10 R8 full paged read");

    // R11: abort a pending write, then a stray pulse, then a fresh command
    wr_start(8'h0F, 8'h0A, 8'h00, 8'h00, "R11 aborted write");
    bevt("R11 abort");
    pulse("R11 pulse after abort");
    rd_all(8'hAA, 8'h02, 8'h00, "R11 R9 new command");
    rd_all(8'hC3, 8'h3E, 8'h00, "R11 R8 page boundary");

    // R12: unknown command
    send(8'h99, "R12 unknown");
    get(8'hFF, "R12 ones reply");
    send(8'h0F, "R12 ignored byte");
    pulse("R12 ignored pulse");
    get(8'hFF, "R12 ones reply");
    bevt("R11");
    rd_all(8'hF0, 8'h00, 8'h00, "R12 R7 full read");

    // R5 R1: status writes across the fixed byte and the wrap
    wr_start(8'h55, 8'h06, 8'h00, 8'h5A, "R5 status run");
    wr_prog("R5 status run");
    wr_more(8'hFF, "R1 fixed status byte");
    wr_prog("R1 fixed status byte");
    wr_more(8'hFF, "R5 status wrap");
    wr_prog("R5 status wrap");
    bevt("R11");
    rd_all(8'hAA, 8'h00, 8'h00, "R9 status final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule